// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit watches a set of general-purpose input pins, grouped in banks of 32, and records selected level transitions into one sticky status word per bank. Each pin has a rising-edge enable and a falling-edge enable, and it can latch a transition only while its direction bit marks it as an input. Software reads the status words. It clears individual bits by strobing a per-bank clear with a data word, in which each 1 clears the matching status bit.

Three interrupt lines are derived from the status. Bank 0 pin 0 and bank 0 pin 1 each drive a dedicated line. Every other status bit feeds a shared line. While the processor reports that it is halted, a level change on an input pin inside a fixed per-bank eligibility mask raises a one-cycle wake pulse. The pin levels are asynchronous and are resynchronised inside the unit. Pins whose global index is at or above the `LINES` parameter are never observed.

Top module: `gpio_ed_top`

## Requirements
- R1: A 0-to-1 change on pin `pin_async[i]` sets `status[i]` within three clock cycles, provided that `rise_en[i]`=1 and `dir[i]`=0 (0 means input).
- R2: A 1-to-0 change on pin i sets `status[i]` within three clock cycles, provided that `fall_en[i]`=1 and `dir[i]`=0.
- R3: A status bit stays set until it is cleared. A cycle with `clr_we[b]`=1 clears the bits of bank b (`status[b*32+j]`) for which `clr_data[b*32+j]`=1. Bits whose data bit is 0 are unchanged.
- R4: If a newly detected edge and a clear reach the same status bit in the same cycle, the bit ends up set.
- R5: A pin with `dir[i]`=1 (output) never sets its status bit, whatever its level does.
- R6: `irq_pin0` follows `status[0]` and `irq_pin1` follows `status[1]`, each one cycle later.
- R7: `irq_shared` is, one cycle later, the OR of `status[31:2]` and all status bits of banks 1 and up.
- R8: While `halted`=1, a level change on an input pin inside the wake mask gives `wake`=1 for exactly one cycle. The masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F; bit j of a mask covers pin j of that bank.
- R9: `wake` stays 0 when `halted`=0 during the change, when the pin lies outside its bank's mask, or when the pin is an output.
- R10: Pins with index at or above `LINES` never set status and never cause a wake pulse.
- R11: After reset, all status bits, all three interrupt lines and `wake` are 0.
- R12: A transition whose enable is 0 for its direction leaves the status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_async | input | NUM_BANKS*32 | Asynchronous pin levels |
| dir | input | NUM_BANKS*32 | Direction per pin, 1 = output |
| rise_en | input | NUM_BANKS*32 | Rising-edge enable per pin |
| fall_en | input | NUM_BANKS*32 | Falling-edge enable per pin |
| clr_we | input | NUM_BANKS | Per-bank clear strobe |
| clr_data | input | NUM_BANKS*32 | Clear data, a 1 clears the status bit |
| halted | input | 1 | Processor halted indication |
| status | output | NUM_BANKS*32 | Sticky edge status |
| irq_pin0 | output | 1 | Interrupt for bank 0 pin 0 |
| irq_pin1 | output | 1 | Interrupt for bank 0 pin 1 |
| irq_shared | output | 1 | Interrupt for all other status bits |
| wake | output | 1 | One-cycle wake request |

## Verification
Some properties are checked on every cycle. A status bit never drops without a matching clear. Output pins never gain status. The three interrupt lines track the status with one cycle of delay. A wake pulse only follows a cycle with halted high. Ignored pins never hold status. The bench scenarios cover what needs a chosen stimulus. These are the edge polarities with their enables, write-zero clears, and the edge-beats-clear collision placed in the exact cycle. They also cover the wake mask selection, including a pin outside the mask and an output pin inside it, and the line-count cut-off.

// File: rtl/gpio_ed_pkg.sv
package gpio_ed_pkg;
  localparam int unsigned BANK_W = 32;

  // fixed wake-eligibility mask, repeating every four banks
  function automatic logic [31:0] wake_mask(input int unsigned bank);
    logic [31:0] m;
    case (bank % 4)
      0:       m = 32'h8003_FE1B;
      1:       m = 32'h0020_01FC;
      2:       m = 32'hEC08_0000;
      default: m = 32'h0012_007F;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/gpio_ed_rstsync.sv
module gpio_ed_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_s = sh_q[1];
endmodule

// File: rtl/gpio_ed_sync.sv
module gpio_ed_sync #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_ed_bank.sv
module gpio_ed_bank
  import gpio_ed_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned BANK  = 0,
  parameter int unsigned LINES = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] status,
  output logic         wake_hit
);
  localparam logic [W-1:0] WMASK = W'(wake_mask(BANK));

  logic [W-1:0] valid;
  logic [W-1:0] prev_q;
  logic [W-1:0] st_q, st_d;
  logic [W-1:0] rise_ev, fall_ev, set_v, clr_v;
  logic         st_en;

  for (genvar i = 0; i < W; i++) begin : g_valid
    assign valid[i] = ((BANK * W + i) < LINES) ? 1'b1 : 1'b0;
  end

  always_comb begin
    rise_ev  = lvl & ~prev_q & rise_en & ~dir & valid;
    fall_ev  = ~lvl & prev_q & fall_en & ~dir & valid;
    set_v    = rise_ev | fall_ev;
    clr_v    = clr_we ? clr_data : '0;
    // a fresh edge overrides a simultaneous clear
    st_d     = (st_q & ~clr_v) | set_v;
    st_en    = clr_we | (|set_v);
    wake_hit = |((lvl ^ prev_q) & ~dir & valid & WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      st_q   <= '0;
    end else begin
      prev_q <= lvl;
      if (st_en) st_q <= st_d;
    end
  end

  assign status = st_q;
endmodule

// File: rtl/gpio_ed_irq.sv
module gpio_ed_irq #(
  parameter int unsigned NB = 4,
  parameter int unsigned W  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB*W-1:0] status_all,
  input  logic [NB-1:0]   wake_hit,
  input  logic            halted,
  output logic            irq_pin0,
  output logic            irq_pin1,
  output logic            irq_shared,
  output logic            wake
);
  logic i0_d, i1_d, ix_d, wk_d;
  logic i0_q, i1_q, ix_q, wk_q;

  always_comb begin
    i0_d = status_all[0];
    i1_d = status_all[1];
    ix_d = |status_all[NB*W-1:2];
    wk_d = halted & (|wake_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i0_q <= 1'b0;
      i1_q <= 1'b0;
      ix_q <= 1'b0;
      wk_q <= 1'b0;
    end else begin
      i0_q <= i0_d;
      i1_q <= i1_d;
      ix_q <= ix_d;
      wk_q <= wk_d;
    end
  end

  assign irq_pin0   = i0_q;
  assign irq_pin1   = i1_q;
  assign irq_shared = ix_q;
  assign wake       = wk_q;
endmodule

// File: rtl/gpio_ed_top.sv
module gpio_ed_top
  import gpio_ed_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned LINES     = 128
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_async,
  input  logic [NUM_BANKS*BANK_W-1:0] dir,
  input  logic [NUM_BANKS*BANK_W-1:0] rise_en,
  input  logic [NUM_BANKS*BANK_W-1:0] fall_en,
  input  logic [NUM_BANKS-1:0]        clr_we,
  input  logic [NUM_BANKS*BANK_W-1:0] clr_data,
  input  logic                        halted,
  output logic [NUM_BANKS*BANK_W-1:0] status,
  output logic                        irq_pin0,
  output logic                        irq_pin1,
  output logic                        irq_shared,
  output logic                        wake
);
  localparam int unsigned W    = BANK_W;
  localparam int unsigned NPIN = NUM_BANKS * W;

  logic            rst_n_s;
  logic [NPIN-1:0] lvl;
  logic [NUM_BANKS-1:0] wake_hit;

  gpio_ed_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  gpio_ed_sync #(.N(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (pin_async),
    .q     (lvl)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_ed_bank #(.W(W), .BANK(b), .LINES(LINES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .lvl      (lvl[b*W +: W]),
      .dir      (dir[b*W +: W]),
      .rise_en  (rise_en[b*W +: W]),
      .fall_en  (fall_en[b*W +: W]),
      .clr_we   (clr_we[b]),
      .clr_data (clr_data[b*W +: W]),
      .status   (status[b*W +: W]),
      .wake_hit (wake_hit[b])
    );
  end

  gpio_ed_irq #(.NB(NUM_BANKS), .W(W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .status_all (status),
    .wake_hit   (wake_hit),
    .halted     (halted),
    .irq_pin0   (irq_pin0),
    .irq_pin1   (irq_pin1),
    .irq_shared (irq_shared),
    .wake       (wake)
  );
endmodule

// File: rtl/gpio_ed_chk.sv
module gpio_ed_chk #(
  parameter int unsigned NB    = 4,
  parameter int unsigned W     = 32,
  parameter int unsigned LINES = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NB*W-1:0] dir,
  input logic [NB-1:0]   clr_we,
  input logic [NB*W-1:0] clr_data,
  input logic            halted,
  input logic [NB*W-1:0] status,
  input logic            irq_pin0,
  input logic            irq_pin1,
  input logic            irq_shared,
  input logic            wake
);
  logic [NB*W-1:0] clr_mask;

  for (genvar b = 0; b < NB; b++) begin : g_cm
    assign clr_mask[b*W +: W] = clr_we[b] ? clr_data[b*W +: W] : '0;
  end

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(clr_mask)) & ~status) == '0));

  // R6
  irq0_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_pin0 == $past(status[0])));

  // R6
  irq1_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_pin1 == $past(status[1])));

  // R7
  irq_shared_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_shared == $past(|status[NB*W-1:2])));

  // R9
  wake_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(halted));

  for (genvar i = 0; i < NB*W; i++) begin : g_bit
    // R5
    out_pin_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |-> !$past(dir[i]));
    if (i >= LINES) begin : g_ign
      // R10
      ignored_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[i] == 1'b0);
    end
  end
endmodule

bind gpio_ed_top gpio_ed_chk #(.NB(NUM_BANKS), .W(gpio_ed_pkg::BANK_W), .LINES(LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dir        (dir),
  .clr_we     (clr_we),
  .clr_data   (clr_data),
  .halted     (halted),
  .status     (status),
  .irq_pin0   (irq_pin0),
  .irq_pin1   (irq_pin1),
  .irq_shared (irq_shared),
  .wake       (wake)
);

// File: tb/gpio_ed_top_tb.sv
module gpio_ed_top_tb;
  localparam int NB    = 4;
  localparam int LINES = 120;
  localparam int NP    = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_async, dir, rise_en, fall_en, clr_data;
  logic [NB-1:0] clr_we;
  logic          halted;
  logic [NP-1:0] status;
  logic          irq_pin0, irq_pin1, irq_shared, wake;

  always #5 clk = ~clk;

  gpio_ed_top #(.NUM_BANKS(NB), .LINES(LINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .dir(dir),
    .rise_en(rise_en), .fall_en(fall_en), .clr_we(clr_we),
    .clr_data(clr_data), .halted(halted), .status(status),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared),
    .wake(wake)
  );

  typedef struct {
    string       tag;
    logic [31:0] st [NB];
    int          wk;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mst [NB];
  int          exp_wake = 0;
  int          wake_cnt = 0;
  int          checks   = 0;
  int          failures = 0;
  bit          done     = 0;

  function automatic logic [31:0] wmask(int b);
    case (b)
      0:       return 32'h8003_FE1B;
      1:       return 32'h0020_01FC;
      2:       return 32'hEC08_0000;
      default: return 32'h0012_007F;
    endcase
  endfunction

  function automatic logic [31:0] valid_bits(int b);
    logic [31:0] v;
    for (int j = 0; j < 32; j++) v[j] = ((b * 32 + j) < LINES);
    return v;
  endfunction

  always @(negedge clk) if (rst_n === 1'b1 && wake === 1'b1) wake_cnt++;

  // driver side: update the model from the requirements, then drive
  task automatic set_pins(int b, logic [31:0] v);
    logic [31:0] old, inp, chg;
    old = pin_async[b*32 +: 32];
    inp = ~dir[b*32 +: 32] & valid_bits(b);
    mst[b] |= (rise_en[b*32 +: 32] & ~old & v & inp) |
              (fall_en[b*32 +: 32] & old & ~v & inp);
    chg = (old ^ v) & inp & wmask(b);
    if (halted && chg != 0) exp_wake++;
    pin_async[b*32 +: 32] = v;
    @(negedge clk);
  endtask

  task automatic clear(int b, logic [31:0] v);
    mst[b] &= ~v;
    clr_we[b] = 1'b1;
    clr_data[b*32 +: 32] = v;
    @(negedge clk);
    clr_we[b] = 1'b0;
    clr_data[b*32 +: 32] = '0;
  endtask

  // R4: the clear lands on the same edge where the new edge is latched
  task automatic race(int b, logic [31:0] v, logic [31:0] c);
    logic [31:0] old, setv;
    old  = pin_async[b*32 +: 32];
    setv = rise_en[b*32 +: 32] & ~old & v & ~dir[b*32 +: 32] & valid_bits(b);
    pin_async[b*32 +: 32] = v;
    repeat (2) @(negedge clk);
    clr_we[b] = 1'b1;
    clr_data[b*32 +: 32] = c;
    @(negedge clk);
    clr_we[b] = 1'b0;
    clr_data[b*32 +: 32] = '0;
    mst[b] = (mst[b] & ~c) | setv;
  endtask

  task automatic check(string tag);
    exp_t it;
    repeat (5) @(negedge clk);
    it.tag = tag;
    for (int b = 0; b < NB; b++) it.st[b] = mst[b];
    it.wk = exp_wake;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  // monitor side: pop expected items and compare with the ports
  initial begin
    exp_t it;
    logic ex;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      for (int b = 0; b < NB; b++) begin
        checks++;
        if (status[b*32 +: 32] !== it.st[b]) begin
          failures++;
          $display("FAIL %s bank%0d status actual=%h expected=%h", it.tag, b,
                   status[b*32 +: 32], it.st[b]);
        end
      end
      ex = (|it.st[0][31:2]) | (|it.st[1]) | (|it.st[2]) | (|it.st[3]);
      checks++;
      if ({irq_pin0, irq_pin1, irq_shared} !== {it.st[0][0], it.st[0][1], ex}) begin
        failures++;
        $display("FAIL %s irq {0,1,shared} actual=%b expected=%b", it.tag,
                 {irq_pin0, irq_pin1, irq_shared}, {it.st[0][0], it.st[0][1], ex});
      end
      checks++;
      if (wake_cnt != it.wk) begin
        failures++;
        $display("FAIL %s wake pulses actual=%0d expected=%0d", it.tag, wake_cnt, it.wk);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_async = '0; dir = '0; rise_en = '0; fall_en = '0;
    clr_we = '0; clr_data = '0; halted = 1'b0;
    for (int b = 0; b < NB; b++) mst[b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 reset state");

    rise_en = '1;
    set_pins(0, 32'h0000_0001); check("R1 rising bank0 pin0, R6 irq_pin0");
    set_pins(0, 32'h0000_0003); check("R6 irq_pin1");
    clear(0, 32'h0000_0001);    check("R3 write-one clear");
    clear(0, 32'h0000_0000);    check("R3 write-zero no effect");

    rise_en[32 +: 32] = '0;
    fall_en[32 +: 32] = 32'h0000_00FF;
    set_pins(1, 32'h0000_000F); check("R12 disabled rise ignored");
    set_pins(1, 32'h0000_0000); check("R2 falling bank1, R7 shared set");
    clear(1, 32'h0000_000F);
    clear(0, 32'h0000_0002);    check("R7 shared low after clears");

    dir[64 +: 32] = 32'hFFFF_0000;
    set_pins(2, 32'hFFFF_FFFF); check("R5 output pins never latch");
    clear(2, 32'hFFFF_FFFF);

    set_pins(3, 32'hFF00_0000); check("R10 pins above line count ignored");

    race(0, 32'h0000_0023, 32'h0000_0020); check("R4 edge wins over clear");

    set_pins(0, 32'h0000_0022); check("R9 no wake while running");
    halted = 1'b1;
    @(negedge clk);
    set_pins(0, 32'h0000_0026); check("R9 pin outside wake mask");
    set_pins(0, 32'h0000_002E); check("R8 wake pulse bank0 pin3");
    dir[4] = 1'b1;
    @(negedge clk);
    set_pins(0, 32'h0000_003E); check("R9 output pin in mask");
    dir[64 +: 32] = '0;
    @(negedge clk);
    set_pins(2, 32'hFFF7_FFFF); check("R8 wake pulse bank2 pin19");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule